// File: doc/BRIEF.md
# Oversampling Accumulate-and-Dump Filter

This block sits behind a 12-bit converter and turns a stream of samples, each marked by a one-cycle valid strobe, into one result per window. A window holds a power-of-two number of samples, from 1 up to 256, chosen by a 4-bit log2 field. The samples of a window are summed in a 20-bit accumulator. When the last sample of the window arrives, the complete sum is captured in a result register and a full flag is raised. The accumulator then restarts from zero, so the next sample opens the next window without a gap. The result rate is therefore the sample rate divided by the window length.

Two scaled views of the captured sum are offered at the same time. The first is the window average: the sum shifted right by log2 of the count. The second is a resolution-enhanced value: the sum shifted right by half of log2 of the count, rounded down, and kept as 16 bits. With 256 samples and dithered input this gives four extra bits. Software acknowledges a result with a read-acknowledge pulse, which drops the flag.

Top module: `oversample_accum`

## Requirements
- R1: A synchronous reset (active high `rst`) clears the accumulator, the sample count, the captured sum and the full flag, so `sumOut`, `avgOut`, `enhOut` and `fullFlag` all read 0 after it. The window field resets to 8 (256 samples).
- R2: A `cfgWrite` pulse loads `cfgLog2` as k, and the window becomes 2^k samples. Values 0 to 8 are legal. Any value above 8 is treated as 8.
- R3: On the clock edge that accepts the last sample of a window, the sum of all the window's samples, including that last one, is registered. It appears on `sumOut` and `fullFlag` reads 1 from that edge on.
- R4: The accumulator restarts from zero on that same edge. The next valid sample, even on the very next cycle, is counted as the first sample of the new window.
- R5: `fullFlag` stays at 1 until a `readAck` pulse clears it on the following edge. If a window completes on the same edge as `readAck`, the flag stays at 1.
- R6: `avgOut` equals the captured sum shifted right by the k in force when that window completed, truncated to 12 bits.
- R7: `enhOut` equals the captured sum shifted right by floor(k/2) for that same k, truncated to 16 bits. For k = 8 this is a 4-bit shift.
- R8: A `cfgWrite` restarts the current window and discards the partial sum. A sample presented on the same cycle as `cfgWrite` is dropped. `sumOut` and `fullFlag` are not changed by the write.
- R9: Cycles with `sampleValid` low add nothing to the sum. `sumOut` holds its value between window completions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sampleValid | input | 1 | Marks `sampleData` as a new sample this cycle |
| sampleData | input | 12 | Unsigned converter sample |
| cfgWrite | input | 1 | Loads `cfgLog2` and restarts the window |
| cfgLog2 | input | 4 | log2 of the window length, 0 to 8 |
| readAck | input | 1 | Clears the full flag |
| fullFlag | output | 1 | A completed result is waiting |
| sumOut | output | 20 | Raw sum of the last completed window |
| avgOut | output | 12 | Window average |
| enhOut | output | 16 | Resolution-enhanced result |

## Verification
The bench drives windows of every length from 1 to 256, including back-to-back windows with no idle cycle between them. A design that dropped or doubled the boundary sample would produce a sum that is off by one sample in either the closing window or the opening one. The bench also runs odd k values, where a shifter that rounds half of k up instead of down gives an enhanced value half the expected size. It drives all-ones input at 256 samples, where a narrow accumulator or a wrong shift would wrap. Finally it checks a write of an over-range k, which must clamp to 256 samples, and a sample that coincides with a configuration write, which must vanish. An acknowledge that lands on the same edge as a completion must leave the flag set, otherwise a fresh result would go unnoticed.

// File: rtl/ovs_pkg.sv
package ovs_pkg;

  // Strobes issued by the control to the datapath each cycle.
  typedef struct packed {
    logic clearAcc;   // discard partial sum (window restart)
    logic addSample;  // add the incoming sample, window continues
    logic latchSum;   // last sample: capture total, restart accumulator
  } ovs_strobe_t;

endpackage

// File: rtl/ovs_shift.sv
// Logarithmic right shifter: one mux stage per bit of the shift amount.
module ovs_shift #(
  parameter int IN_W  = 20,
  parameter int OUT_W = 12,
  parameter int SH_W  = 4
) (
  input  logic [IN_W-1:0]  din,
  input  logic [SH_W-1:0]  shAmt,
  output logic [OUT_W-1:0] dout
);

  logic [IN_W-1:0] stage [SH_W+1];

  assign stage[0] = din;

  generate
    for (genvar s = 0; s < SH_W; s++) begin : g_stage
      localparam int DIST = 1 << s;
      if (DIST >= IN_W) begin : g_clear
        assign stage[s+1] = shAmt[s] ? '0 : stage[s];
      end else begin : g_move
        assign stage[s+1] = shAmt[s] ? (stage[s] >> DIST) : stage[s];
      end
    end
  endgenerate

  assign dout = OUT_W'(stage[SH_W]);

endmodule

// File: rtl/ovs_ctrl.sv
// Window control: length register, sample counter, full flag, strobes.
module ovs_ctrl
  import ovs_pkg::*;
#(
  parameter int MAX_LOG2 = 8,
  parameter int LOG2_W   = 4,
  parameter int CNT_W    = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sampleValid,
  input  logic              cfgWrite,
  input  logic [LOG2_W-1:0] cfgLog2,
  input  logic              readAck,
  output ovs_strobe_t       strobes,
  output logic [LOG2_W-1:0] curLog2,
  output logic              fullFlag
);

  localparam logic [LOG2_W-1:0] LOG2_MAX = LOG2_W'(MAX_LOG2);

  logic [LOG2_W-1:0] log2Reg;
  logic [LOG2_W-1:0] log2Clamped;
  logic [CNT_W-1:0]  sampleCnt;
  logic [CNT_W-1:0]  windowLast;
  logic              isLast;
  logic              takeSample;

  assign log2Clamped = (cfgLog2 > LOG2_MAX) ? LOG2_MAX : cfgLog2;
  assign windowLast  = (CNT_W'(1) << log2Reg) - CNT_W'(1);
  assign isLast      = (sampleCnt == windowLast);
  assign takeSample  = sampleValid && !cfgWrite;

  always_comb begin
    strobes           = '0;
    strobes.clearAcc  = cfgWrite;
    strobes.addSample = takeSample && !isLast;
    strobes.latchSum  = takeSample && isLast;
  end

  assign curLog2 = log2Reg;

  always_ff @(posedge clk) begin
    if (rst) begin
      log2Reg <= LOG2_MAX;
    end else if (cfgWrite) begin
      log2Reg <= log2Clamped;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sampleCnt <= '0;
    end else if (cfgWrite || strobes.latchSum) begin
      sampleCnt <= '0;
    end else if (strobes.addSample) begin
      sampleCnt <= sampleCnt + CNT_W'(1);
    end
  end

  // Completion has priority over acknowledge so a new result is never lost.
  always_ff @(posedge clk) begin
    if (rst) begin
      fullFlag <= 1'b0;
    end else if (strobes.latchSum) begin
      fullFlag <= 1'b1;
    end else if (readAck) begin
      fullFlag <= 1'b0;
    end
  end

  // R2: the window length register never holds an illegal value
  p_log2_legal_r2: assert property (@(posedge clk) disable iff (rst)
    log2Reg <= LOG2_MAX);

  // R2: the count never runs past the programmed window
  p_count_bound_r2: assert property (@(posedge clk) disable iff (rst)
    sampleCnt <= windowLast);

  // R3: a completed window raises the flag on the next cycle
  p_full_set_r3: assert property (@(posedge clk) disable iff (rst)
    strobes.latchSum |=> fullFlag);

  // R5: an acknowledge without a completion drops the flag
  p_ack_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (readAck && !strobes.latchSum) |=> !fullFlag);

  // R5: the flag never rises without a completion
  p_full_cause_r5: assert property (@(posedge clk) disable iff (rst)
    (!fullFlag && !strobes.latchSum) |=> !fullFlag);

  // R8: a configuration write restarts the count
  p_cfg_restart_r8: assert property (@(posedge clk) disable iff (rst)
    cfgWrite |=> (sampleCnt == '0));

endmodule

// File: rtl/ovs_datapath.sv
// Accumulator, captured sum and the two scaled views.
module ovs_datapath
  import ovs_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int ACC_W    = 20,
  parameter int ENH_W    = 16,
  parameter int LOG2_W   = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  ovs_strobe_t         strobes,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  logic [LOG2_W-1:0]   curLog2,
  output logic [ACC_W-1:0]    sumOut,
  output logic [SAMPLE_W-1:0] avgOut,
  output logic [ENH_W-1:0]    enhOut
);

  logic [ACC_W-1:0]  acc;
  logic [ACC_W-1:0]  accPlus;
  logic [ACC_W-1:0]  sumReg;
  logic [LOG2_W-1:0] sumLog2;
  logic [LOG2_W-1:0] enhShift;

  assign accPlus = acc + ACC_W'(sampleData);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
    end else if (strobes.clearAcc || strobes.latchSum) begin
      acc <= '0;
    end else if (strobes.addSample) begin
      acc <= accPlus;
    end
  end

  // The window length is captured with the sum so later writes do not
  // rescale a result that is still waiting to be read.
  always_ff @(posedge clk) begin
    if (rst) begin
      sumReg  <= '0;
      sumLog2 <= '0;
    end else if (strobes.latchSum) begin
      sumReg  <= accPlus;
      sumLog2 <= curLog2;
    end
  end

  assign enhShift = sumLog2 >> 1;

  ovs_shift #(
    .IN_W (ACC_W),
    .OUT_W(SAMPLE_W),
    .SH_W (LOG2_W)
  ) u_avgShift (
    .din  (sumReg),
    .shAmt(sumLog2),
    .dout (avgOut)
  );

  ovs_shift #(
    .IN_W (ACC_W),
    .OUT_W(ENH_W),
    .SH_W (LOG2_W)
  ) u_enhShift (
    .din  (sumReg),
    .shAmt(enhShift),
    .dout (enhOut)
  );

  assign sumOut = sumReg;

  // R4: a completed window leaves the accumulator empty
  p_window_restart_r4: assert property (@(posedge clk) disable iff (rst)
    strobes.latchSum |=> (acc == '0));

  // R8: a restart discards the partial sum
  p_clear_zero_r8: assert property (@(posedge clk) disable iff (rst)
    strobes.clearAcc |=> (acc == '0));

  // R9: the captured sum holds between completions
  p_sum_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !strobes.latchSum |=> $stable(sumReg));

  // R9: idle cycles leave the accumulator untouched
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (strobes == '0) |=> $stable(acc));

  // R3: at most one datapath action per cycle
  p_one_action_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobes.addSample, strobes.latchSum}));

endmodule

// File: rtl/oversample_accum.sv
// Top: oversampling accumulate-and-dump filter.
module oversample_accum
  import ovs_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int MAX_LOG2 = 8,
  localparam int LOG2_W  = $clog2(MAX_LOG2 + 1),
  localparam int ACC_W   = SAMPLE_W + MAX_LOG2,
  localparam int ENH_W   = SAMPLE_W + MAX_LOG2 / 2,
  localparam int CNT_W   = MAX_LOG2 + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  logic                cfgWrite,
  input  logic [LOG2_W-1:0]   cfgLog2,
  input  logic                readAck,
  output logic                fullFlag,
  output logic [ACC_W-1:0]    sumOut,
  output logic [SAMPLE_W-1:0] avgOut,
  output logic [ENH_W-1:0]    enhOut
);

  ovs_strobe_t       strobes;
  logic [LOG2_W-1:0] curLog2;

  ovs_ctrl #(
    .MAX_LOG2(MAX_LOG2),
    .LOG2_W  (LOG2_W),
    .CNT_W   (CNT_W)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .sampleValid(sampleValid),
    .cfgWrite   (cfgWrite),
    .cfgLog2    (cfgLog2),
    .readAck    (readAck),
    .strobes    (strobes),
    .curLog2    (curLog2),
    .fullFlag   (fullFlag)
  );

  ovs_datapath #(
    .SAMPLE_W(SAMPLE_W),
    .ACC_W   (ACC_W),
    .ENH_W   (ENH_W),
    .LOG2_W  (LOG2_W)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .sampleData(sampleData),
    .curLog2   (curLog2),
    .sumOut    (sumOut),
    .avgOut    (avgOut),
    .enhOut    (enhOut)
  );

endmodule

// File: tb/sim_oversample_accum.sv
module sim_oversample_accum;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sampleValid = 1'b0;
  logic [11:0] sampleData = '0;
  logic        cfgWrite = 1'b0;
  logic [3:0]  cfgLog2 = '0;
  logic        readAck = 1'b0;
  logic        fullFlag;
  logic [19:0] sumOut;
  logic [11:0] avgOut;
  logic [15:0] enhOut;

  always #5 clk = ~clk;

  oversample_accum u0 (
    .clk        (clk),
    .rst        (rst),
    .sampleValid(sampleValid),
    .sampleData (sampleData),
    .cfgWrite   (cfgWrite),
    .cfgLog2    (cfgLog2),
    .readAck    (readAck),
    .fullFlag   (fullFlag),
    .sumOut     (sumOut),
    .avgOut     (avgOut),
    .enhOut     (enhOut)
  );

  typedef struct {
    longint sumV;
    longint avgV;
    longint enhV;
    longint due;
    string  tag;
  } exp_t;

  exp_t   expQ[$];
  int     nChecks = 0;
  int     nErrors = 0;
  longint cyc = 0;
  bit     done = 1'b0;

  // Bench model of the window (from the requirements)
  longint modelAcc = 0;
  int     modelCnt = 0;
  int     modelK   = 8;
  longint lastSum  = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input longint act, input longint expv);
    nChecks++;
    if (act != expv) begin
      nErrors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Driver: present one sample for one cycle; called at a falling edge.
  task automatic driveSample(input int d, input string tag);
    exp_t e;
    sampleValid = 1'b1;
    sampleData  = d[11:0];
    modelAcc += d;
    modelCnt++;
    if (modelCnt == (1 << modelK)) begin
      e.sumV = modelAcc;
      e.avgV = (modelAcc >> modelK) & 4095;
      e.enhV = (modelAcc >> (modelK / 2)) & 65535;
      e.due  = cyc + 1;
      e.tag  = tag;
      expQ.push_back(e);
      lastSum  = modelAcc;
      modelAcc = 0;
      modelCnt = 0;
    end
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  task automatic setWindow(input int k);
    cfgLog2  = k[3:0];
    cfgWrite = 1'b1;
    modelK   = (k > 8) ? 8 : k;
    modelAcc = 0;
    modelCnt = 0;
    @(negedge clk);
    cfgWrite = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Monitor: compare each completed window on the cycle it is due.
  always @(negedge clk) begin
    if (!rst && expQ.size() > 0 && expQ[0].due == cyc) begin
      exp_t e;
      e = expQ.pop_front();
      chk({"R3 sum ", e.tag}, longint'(sumOut), e.sumV);
      chk({"R3 flag ", e.tag}, longint'(fullFlag), 1);
      chk({"R6 avg ", e.tag}, longint'(avgOut), e.avgV);
      chk({"R7 enh ", e.tag}, longint'(enhOut), e.enhV);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nErrors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    logic [19:0] heldSum;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    chk("R1 sumOut", longint'(sumOut), 0);
    chk("R1 avgOut", longint'(avgOut), 0);
    chk("R1 enhOut", longint'(enhOut), 0);
    chk("R1 fullFlag", longint'(fullFlag), 0);

    // R1/R2: reset window is 256 samples; ramp pattern
    for (int i = 0; i < 256; i++) driveSample((i * 37 + 5) % 4096, "R1 default 256");
    idle(2);

    // R7: all-ones at 256 samples, widest sum
    for (int i = 0; i < 256; i++) driveSample(4095, "R7 full-scale 256");
    idle(2);

    // R5: acknowledge clears the flag on the next edge
    chk("R5 flag before ack", longint'(fullFlag), 1);
    readAck = 1'b1;
    @(negedge clk);
    readAck = 1'b0;
    chk("R5 flag after ack", longint'(fullFlag), 0);

    // R2/R4: single-sample windows back to back
    setWindow(0);
    driveSample(100, "R4 k0 a");
    driveSample(4095, "R4 k0 b");
    driveSample(7, "R4 k0 c");
    idle(2);

    // R4: continuous valid across several 4-sample windows
    setWindow(2);
    for (int i = 0; i < 12; i++) driveSample(300 * i + 11, "R4 k2 continuous");
    idle(2);

    // R9: k=3 with idle gaps; sum holds in between
    setWindow(3);
    for (int i = 0; i < 8; i++) begin
      driveSample(1000 + 13 * i, "R9 k3 gaps");
      idle(i % 3);
    end
    idle(2);
    heldSum = sumOut;
    idle(5);
    chk("R9 sum held during idle", longint'(sumOut), longint'(heldSum));
    chk("R9 sum equals last window", longint'(sumOut), lastSum);

    // R7: odd k values use floor(k/2)
    setWindow(1);
    driveSample(4001, "R7 k1 a");
    driveSample(2, "R7 k1 b");
    setWindow(5);
    for (int i = 0; i < 32; i++) driveSample((i * 123) % 4096, "R7 k5");
    setWindow(7);
    for (int i = 0; i < 128; i++) driveSample(4095 - (i * 29) % 4096, "R7 k7");
    setWindow(4);
    for (int i = 0; i < 16; i++) driveSample(i * 250, "R6 k4");
    idle(2);

    // R5: completion on the same edge as acknowledge keeps the flag
    setWindow(1);
    driveSample(10, "R5 pre");
    readAck = 1'b1;
    driveSample(20, "R5 ack with completion");
    readAck = 1'b0;
    chk("R5 flag kept on coincident ack", longint'(fullFlag), 1);

    // R8: write restarts window, coincident sample dropped, outputs kept
    setWindow(2);
    driveSample(500, "R8 partial");
    driveSample(600, "R8 partial");
    heldSum = sumOut;
    sampleValid = 1'b1;
    sampleData  = 12'd4000;
    setWindow(2);
    sampleValid = 1'b0;
    chk("R8 sum unchanged by write", longint'(sumOut), longint'(heldSum));
    chk("R8 flag unchanged by write", longint'(fullFlag), 1);
    driveSample(1, "R8 fresh window");
    driveSample(2, "R8 fresh window");
    driveSample(3, "R8 fresh window");
    driveSample(4, "R8 fresh window");
    idle(2);
    chk("R8 fresh window sum", longint'(sumOut), 10);

    // R2: over-range field is treated as 8
    setWindow(12);
    for (int i = 0; i < 256; i++) driveSample((i * 511) % 4096, "R2 clamp to 256");
    idle(3);

    chk("R3 every window reported", longint'(expQ.size()), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule